// File: doc/BRIEF.md
# Fractional-Rate Serial Receiver

This block receives asynchronous serial words (one low start bit, 1 to 32 data bits sent least significant bit first, one high stop bit) from a single line. A 32-bit setup word fixes both the bit period and the word length. When any of the six most significant bits of the setup word is set, the period is a whole number of clocks. When those six bits are all clear, the period becomes a 10-bit integer with a 6-bit fraction. This keeps short periods, only a few clocks long, accurate.

The receiver confirms each start bit at its midpoint. It samples every data bit and the stop bit half a period into the bit. It carries the fractional remainder from bit to bit, so the sample point does not drift over a long word. Each finished word appears right-aligned on a 32-bit output, together with a one-cycle valid pulse and a framing-error flag. A setup word loaded while a word is arriving is held back and used from the next start bit on.

Top module: `frac_uart_rx`

## Requirements
- R1: While reset is high and after it is released, `rx_valid`, `rx_ferr` and `rx_data` are zero until the first word completes.
- R2: When setup bits [31:26] are not all zero, the bit period is setup bits [31:16] clocks. Setup bits [4:0] always hold the word length minus one.
- R3: When setup bits [31:26] are all zero, the bit period is setup bits [25:10] divided by 64 clocks. For example, 0x000D5407 gives 853/64 clocks per bit and 8-bit words.
- R4: The fractional remainder is carried from bit to bit, so a 32-bit word at 10.5 clocks per bit is received without error.
- R5: A low pulse that is gone again at the start bit's midpoint is discarded, and no word is produced.
- R6: Data bits are taken least significant first. The word is right-aligned in `rx_data`, and every bit above the word length reads zero.
- R7: A stop bit sampled low sets `rx_ferr` with that word's valid pulse. After such an error, no new start is seen until the line has returned high.
- R8: Each received word gives exactly one single-cycle `rx_valid` pulse. `rx_data` and `rx_ferr` hold their values until the next word completes.
- R9: A setup word loaded with `cfg_load` while a word is arriving does not change that word's timing. It applies from the next start bit.
- R10: Word lengths of both 1 bit and 32 bits are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial line, idle high, asynchronous to clk |
| cfg_word | input | 32 | Setup word: bit period and word length |
| cfg_load | input | 1 | Captures `cfg_word` for use from the next start bit |
| rx_data | output | 32 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when a word completes |
| rx_ferr | output | 1 | Stop bit of the last word was low |

## Verification
Words are sent at a fractional period of 853/64 clocks, at integer periods of 1024 and 8333 clocks, and at 10.5 clocks with 32-bit words. Together these separate the two decode modes, and they show whether the fraction is carried or dropped: a dropped fraction lets the sample point slide out of the later bits. Alternating, all-zero, all-one and single-bit-set data patterns expose bit-order or shift errors. A 5-bit word with a high-bits-set source value checks that the unused upper bits are cleared. A short low glitch, a low stop bit followed by a held-low line, and a setup change in the middle of a word each check that the receiver rejects, waits, or defers exactly where it should.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int CFG_W    = 32;
  localparam int FRAC_W   = 6;
  localparam int INT_W    = 16;
  localparam int PER_W    = INT_W + FRAC_W;
  localparam int LEN_W    = 5;
  localparam int DATA_W   = 1 << LEN_W;
  localparam int MODE_W   = 6;
  // field positions that the decoder relies on
  localparam int WHOLE_LO = CFG_W - INT_W;
  localparam int FIX_HI   = CFG_W - MODE_W - 1;
  localparam int FIX_LO   = FIX_HI - INT_W + 1;
  localparam int MIN_PER  = 2 << FRAC_W;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic [LEN_W-1:0] last_idx;
  } frx_cfg_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP,
    S_BREAK
  } frx_state_t;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/frx_cfg_decode.sv
module frx_cfg_decode
  import frx_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  output frx_cfg_t         dec
);
  logic fix_mode;
  logic cfg_unused_bits;

  assign cfg_unused_bits = ^cfg_word[FIX_LO-1:LEN_W];

  always_comb begin
    fix_mode = (cfg_word[CFG_W-1:CFG_W-MODE_W] == '0);
    if (fix_mode) begin
      dec.period = PER_W'(cfg_word[FIX_HI:FIX_LO]);
      // keep very short fractional periods workable
      if (dec.period < PER_W'(MIN_PER)) dec.period = PER_W'(MIN_PER);
    end else begin
      dec.period = {cfg_word[CFG_W-1:WHOLE_LO], {FRAC_W{1'b0}}};
    end
    dec.last_idx = cfg_word[LEN_W-1:0];
  end
endmodule

// File: rtl/frx_bit_timer.sv
module frx_bit_timer
  import frx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             halt,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  localparam int CNT_W = PER_W + 1 - FRAC_W;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  span_int;
  logic [FRAC_W-1:0] ph;
  logic [PER_W:0]    span;
  logic              run;

  assign tick = run && (cnt == '0);

  // next interval in fixed point: half period on launch, else period plus carried fraction
  always_comb begin
    if (launch) span = {1'b0, period} >> 1;
    else        span = {1'b0, period} + (PER_W+1)'(ph);
    span_int = span[PER_W:FRAC_W];
    if (span_int == '0) span_int = CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
      ph  <= '0;
    end else if (halt) begin
      run <= 1'b0;
    end else if (launch) begin
      run <= 1'b1;
      cnt <= span_int - 1'b1;
      ph  <= span[FRAC_W-1:0];
    end else if (tick) begin
      cnt <= span_int - 1'b1;
      ph  <= span[FRAC_W-1:0];
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R4: between sample points the interval counts down one clock at a time
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && !launch && !halt) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/frac_uart_rx.sv
module frac_uart_rx
  import frx_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] RESET_CFG   = 32'h208D_0007
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_in,
  input  logic [31:0] cfg_word,
  input  logic        cfg_load,
  output logic [31:0] rx_data,
  output logic        rx_valid,
  output logic        rx_ferr
);
  logic             rx_s;
  logic [CFG_W-1:0] cfg_pend;
  frx_cfg_t         dec_pend;
  frx_cfg_t         act;
  frx_state_t       state;
  logic [DATA_W-1:0] shreg;
  logic [LEN_W-1:0] bit_idx;
  logic             tick;
  logic             launch;
  logic             halt;
  logic [PER_W-1:0] period_sel;

  frx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_in),
    .dout(rx_s)
  );

  frx_cfg_decode u_dec (
    .cfg_word(cfg_pend),
    .dec     (dec_pend)
  );

  assign launch     = (state == S_IDLE) && !rx_s;
  assign halt       = tick && (((state == S_START) && rx_s) || (state == S_STOP));
  assign period_sel = (state == S_IDLE) ? dec_pend.period : act.period;

  frx_bit_timer u_timer (
    .clk   (clk),
    .rst   (rst),
    .launch(launch),
    .halt  (halt),
    .period(period_sel),
    .tick  (tick)
  );

  // setup word staging: captured any time, adopted at a start bit
  always_ff @(posedge clk) begin
    if (rst)           cfg_pend <= RESET_CFG;
    else if (cfg_load) cfg_pend <= cfg_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      act      <= '0;
      shreg    <= '0;
      bit_idx  <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (!rx_s) begin
            state   <= S_START;
            act     <= dec_pend;
            shreg   <= '0;
            bit_idx <= '0;
          end
        end
        S_START: begin
          if (tick) state <= rx_s ? S_IDLE : S_DATA;
        end
        S_DATA: begin
          if (tick) begin
            shreg[bit_idx] <= rx_s;
            if (bit_idx == act.last_idx) state <= S_STOP;
            else                         bit_idx <= bit_idx + 1'b1;
          end
        end
        S_STOP: begin
          if (tick) begin
            rx_data  <= shreg;
            rx_valid <= 1'b1;
            rx_ferr  <= !rx_s;
            state    <= rx_s ? S_IDLE : S_BREAK;
          end
        end
        S_BREAK: begin
          if (rx_s) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: a completed word raises valid for one cycle only
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8: results do not move between completions
  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_ferr)));

  // R7: the error flag only changes alongside a completion
  p_ferr_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ferr) |-> rx_valid);

  // R7: a held-low line after an error keeps the receiver waiting
  p_break_wait_r7: assert property (@(posedge clk) disable iff (rst)
    ((state == S_BREAK) && !rx_s) |=> (state == S_BREAK));

  // R6: bits above the word length are zero
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> act.last_idx) <= 32'd1));

  // R9: the adopted setup stays fixed for the whole word
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ((state != S_IDLE) && ($past(state) != S_IDLE)) |-> $stable(act));
endmodule

// File: tb/tb_frac_uart_rx.sv
`timescale 1ns/1ps
module tb_frac_uart_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_in = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        cfg_load = 1'b0;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic        rx_ferr;

  int n_tests = 0;
  int n_fail  = 0;
  int n_valid = 0;
  bit done    = 0;

  logic [31:0] exp_d[$];
  logic        exp_f[$];
  string       exp_tag[$];

  always #4 clk = ~clk;

  frac_uart_rx dut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .cfg_word(cfg_word),
    .cfg_load(cfg_load), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_word = w;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // per_fx: bit period in 1/64 clock; drives one frame starting at a falling clock edge
  task automatic send_frame(input longint per_fx, input int nbits, input logic [31:0] d,
                            input logic stop_v, input string tag);
    logic [63:0] mask;
    mask = (64'd1 << nbits) - 64'd1;
    exp_d.push_back(d & mask[31:0]);
    exp_f.push_back(!stop_v);
    exp_tag.push_back(tag);
    for (int k = 0; k < nbits + 2; k++) begin
      longint e0, e1;
      e0 = (longint'(k) * per_fx) >>> 6;
      e1 = (longint'(k + 1) * per_fx) >>> 6;
      if (k == 0)              rx_in = 1'b0;
      else if (k <= nbits)     rx_in = d[k-1];
      else                     rx_in = stop_v;
      repeat (int'(e1 - e0)) @(negedge clk);
    end
  endtask

  task automatic gap(input int n);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      n_valid++;
      if (exp_d.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R8 unexpected word actual=%h expected=none", rx_data);
      end else begin
        string t;
        logic [31:0] d;
        logic f;
        t = exp_tag.pop_front();
        d = exp_d.pop_front();
        f = exp_f.pop_front();
        check({t, " data"}, rx_data, d);
        check({t, " ferr"}, {31'd0, rx_ferr}, {31'd0, f});
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", {31'd0, rx_valid}, 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 data after reset", rx_data, 32'd0);
    check("R1 ferr after reset", {31'd0, rx_ferr}, 32'd0);
    check("R1 valid after reset", {31'd0, rx_valid}, 32'd0);

    // R3 / R6: fractional period 853/64, 8-bit words
    set_cfg(32'h000D_5407);
    gap(10);
    send_frame(853, 8, 32'h55, 1'b1, "R3 frac 0x55");  gap(7);
    send_frame(853, 8, 32'hA3, 1'b1, "R6 lsb-first 0xA3"); gap(3);
    send_frame(853, 8, 32'h00, 1'b1, "R3 zeros");      gap(20);
    send_frame(853, 8, 32'hFF, 1'b1, "R3 ones");       gap(20);

    // R2: integer mode, 1024 clocks per bit
    set_cfg(32'h0400_0007);
    gap(10);
    send_frame(1024 * 64, 8, 32'h3C, 1'b1, "R2 int1024 0x3C"); gap(50);

    // R2 / R10: 8333 clocks per bit, 1-bit words
    set_cfg(32'h208D_0000);
    gap(10);
    send_frame(8333 * 64, 1, 32'h1, 1'b1, "R10 one-bit word"); gap(50);

    // R4 / R10: 10.5 clocks per bit, 32-bit words
    set_cfg(32'h000A_801F);
    gap(10);
    send_frame(672, 32, 32'hDEAD_BEEF, 1'b1, "R4 32b 0xDEADBEEF"); gap(20);
    send_frame(672, 32, 32'h8000_0001, 1'b1, "R10 32b ends");      gap(20);

    // R6: 5-bit words, upper bits cleared
    set_cfg(32'h000D_5404);
    gap(10);
    send_frame(853, 5, 32'hFFFF_FFF5, 1'b1, "R6 5-bit right-aligned"); gap(20);

    // R5: short glitch is dropped
    set_cfg(32'h000D_5407);
    gap(10);
    snap = n_valid;
    rx_in = 1'b0;
    repeat (3) @(negedge clk);
    gap(60);
    check("R5 glitch gives no word", n_valid, snap);
    send_frame(853, 8, 32'h5A, 1'b1, "R5 word after glitch"); gap(20);

    // R7: framing error, then held-low line
    send_frame(853, 8, 32'h81, 1'b0, "R7 bad stop");
    rx_in = 1'b0;
    repeat (80) @(negedge clk);
    snap = n_valid;
    repeat (80) @(negedge clk);
    check("R7 no start while line low", n_valid, snap);
    gap(30);
    send_frame(853, 8, 32'h42, 1'b1, "R7 recovery word"); gap(20);

    // R9: setup change mid-word applies from the next word
    fork
      send_frame(853, 8, 32'h96, 1'b1, "R9 old rate kept");
      begin
        repeat (30) @(negedge clk);
        cfg_word = 32'h000A_8007;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
      end
    join
    gap(20);
    send_frame(672, 8, 32'hC3, 1'b1, "R9 new rate used"); gap(40);

    // R8: every sent word produced exactly one pulse
    check("R8 no missing words", exp_d.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule